// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer

This block is a controller on the host side. It writes a contiguous run of bytes into a byte-wide flash device that takes commands, starting at address zero and ending at an address the caller supplies. The block fetches each byte from a data source over a request/valid handshake. It then programs the byte with a bounded loop of attempts. Each attempt has five steps: a program-setup command, a write of the target address and data, a programming delay, a verify command, and a margin delay. A readback and compare closes the attempt.

When every byte matches, the block returns the device to read mode and reports success. When one byte still mismatches after the maximum number of program pulses, the block stops at that byte. It still returns the device to read mode, then reports failure and holds the address of the failing byte. Both delays and the pulse limit are parameters counted in clock cycles. The bus strobe widths are also parameters. A single `flash_ready` input stands for the programming supply having settled.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `fail` are low. `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high and `fl_dq_oe` is low. The three strobes stay high whenever `busy` is low.
- R2: Every program attempt is one write of the setup command 8'h40, followed directly by one write of the target address with its expected byte. A verify command is only issued after such a data write.
- R3: From the rising edge of `fl_we_n` that ends a data write, at least `PROG_WAIT` clock cycles pass before `fl_we_n` falls for the verify command 8'hC0.
- R4: From the rising edge of `fl_we_n` that ends the verify command, at least `VERIFY_WAIT` clock cycles pass before `fl_oe_n` falls to read the byte back.
- R5: Bytes are fetched exactly once each, in ascending address order from 0. A byte is taken on a cycle where `src_req` and `src_valid` are both high, and `src_addr` gives its address. The block moves to the next address only after the readback equals the fetched byte.
- R6: The pulse count starts at 1 for each byte and rises by one on each mismatch. A byte that needs k pulses, with k not above `MAX_PULSES`, receives exactly k program writes.
- R7: If the byte still mismatches after `MAX_PULSES` pulses, the run ends with `fail` high and `pass` low. `fail_addr` shows the failing address and holds it until the next start. No later address is fetched.
- R8: After the last address matches, the block writes 8'h00 and then asserts `pass`. `pass` and `fail` are never high together.
- R9: A failed run also writes 8'h00 before it ends. Every run ends with `done` high for exactly one cycle, while `busy` drops.
- R10: A start waits for `flash_ready`: no strobe is driven and no byte is requested while it is low. A `start` pulse while `busy` is high has no effect.
- R11: `fl_we_n` and `fl_oe_n` are never low in the same cycle.
- R12: `fl_dq_oe` is never high while `fl_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled when idle) |
| flash_ready | input | 1 | Programming supply settled |
| last_addr | input | ADDR_W | Last address to program |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run succeeded (held) |
| fail | output | 1 | Last run failed (held) |
| fail_addr | output | ADDR_W | Address that failed (held) |
| src_req | output | 1 | Request for the byte at `src_addr` |
| src_addr | output | ADDR_W | Address of the requested byte |
| src_valid | input | 1 | `src_data` valid |
| src_data | input | 8 | Expected byte |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | 8 | Data read from the flash |

## Verification
The checker watches a few properties on every cycle. It checks that the write and read strobes never overlap, and that the data pins are not driven during a read. It checks that an idle block leaves the bus quiet and that the verdict bits are exclusive. It also checks that `done` is a single pulse, that the failing address holds, and that the pulse counter stays within its limit.

Other behaviour needs a flash model in the bench. That covers the order of commands, the two delay windows measured between strobe edges, the exact number of program pulses a slow byte receives, and failure at exactly the pulse limit. It also covers the final read-mode write and the one-time, in-order fetch of source bytes.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_PROGRAM = 8'h40;
  localparam logic [BYTE_W-1:0] OP_VERIFY  = 8'hC0;
  localparam logic [BYTE_W-1:0] OP_READ    = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE, ST_READY, ST_FETCH, ST_SETUP, ST_DATA, ST_PWAIT,
    ST_VCMD, ST_VWAIT, ST_READ, ST_CHECK, ST_EXIT
  } seq_state_t;

  typedef enum logic [1:0] {
    BP_IDLE, BP_SETUP, BP_ACTIVE, BP_HOLD
  } bus_phase_t;
endpackage

// File: rtl/fps_bus.sv
module fps_bus
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int WE_CYCLES = 3,
  parameter int OE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              ack,
  output logic [BYTE_W-1:0] rdata,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [BYTE_W-1:0] dq_i
);
  localparam int PW = (WE_CYCLES > OE_CYCLES) ? WE_CYCLES : OE_CYCLES;
  localparam int CW = $clog2(PW + 1);
  localparam logic [CW-1:0] WE_LIM = CW'(WE_CYCLES - 1);
  localparam logic [CW-1:0] OE_LIM = CW'(OE_CYCLES - 1);

  bus_phase_t    phase;
  logic          rd_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= BP_IDLE;
      rd_q   <= 1'b0;
      cnt    <= '0;
      ack    <= 1'b0;
      rdata  <= '0;
      ce_n   <= 1'b1;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
      addr_o <= '0;
      dq_o   <= '0;
      dq_oe  <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (phase)
        BP_IDLE: if (req) begin
          rd_q   <= rd;
          addr_o <= addr_i;
          dq_o   <= data_i;
          ce_n   <= 1'b0;
          dq_oe  <= ~rd;
          phase  <= BP_SETUP;
        end
        BP_SETUP: begin
          cnt <= '0;
          if (rd_q) oe_n <= 1'b0;
          else      we_n <= 1'b0;
          phase <= BP_ACTIVE;
        end
        BP_ACTIVE: begin
          cnt <= cnt + 1'b1;
          if (cnt == (rd_q ? OE_LIM : WE_LIM)) begin
            we_n <= 1'b1;
            oe_n <= 1'b1;
            if (rd_q) rdata <= dq_i;
            phase <= BP_HOLD;
          end
        end
        default: begin
          ce_n  <= 1'b1;
          dq_oe <= 1'b0;
          ack   <= 1'b1;
          phase <= BP_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          fire
);
  logic [TW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        cnt <= val;
        run <= 1'b1;
      end else if (run) begin
        if (cnt <= TW'(1)) begin
          run  <= 1'b0;
          fire <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int MAX_PULSES  = 25,
  parameter int PROG_WAIT   = 500,
  parameter int VERIFY_WAIT = 300,
  parameter int TW          = 9,
  parameter int PCW         = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              flash_ready,
  input  logic [ADDR_W-1:0] last_addr,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              src_req,
  output logic [ADDR_W-1:0] cur_addr,
  input  logic              src_valid,
  input  logic [BYTE_W-1:0] src_data,
  output logic              bus_req,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_data,
  input  logic              bus_ack,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  input  logic              tmr_fire,
  output logic [PCW-1:0]    pulse_cnt
);
  seq_state_t        state;
  logic [ADDR_W-1:0] last_q;
  logic [BYTE_W-1:0] expect_q;
  logic              pend, ok_q;
  logic              on_bus, want_rd;
  logic [ADDR_W-1:0] want_addr;
  logic [BYTE_W-1:0] want_data;

  always_comb begin
    on_bus    = state inside {ST_SETUP, ST_DATA, ST_VCMD, ST_READ, ST_EXIT};
    want_rd   = (state == ST_READ);
    want_addr = (state == ST_EXIT) ? '0 : cur_addr;
    case (state)
      ST_SETUP: want_data = OP_PROGRAM;
      ST_DATA:  want_data = expect_q;
      ST_VCMD:  want_data = OP_VERIFY;
      default:  want_data = OP_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      src_req   <= 1'b0;
      cur_addr  <= '0;
      last_q    <= '0;
      expect_q  <= '0;
      pend      <= 1'b0;
      ok_q      <= 1'b0;
      bus_req   <= 1'b0;
      bus_rd    <= 1'b0;
      bus_addr  <= '0;
      bus_data  <= '0;
      tmr_load  <= 1'b0;
      tmr_val   <= '0;
      pulse_cnt <= '0;
    end else begin
      bus_req  <= 1'b0;
      tmr_load <= 1'b0;
      done     <= 1'b0;
      if (on_bus && !pend) begin
        bus_req  <= 1'b1;
        pend     <= 1'b1;
        bus_rd   <= want_rd;
        bus_addr <= want_addr;
        bus_data <= want_data;
      end
      if (bus_ack) pend <= 1'b0;

      case (state)
        ST_IDLE: if (start) begin
          busy     <= 1'b1;
          pass     <= 1'b0;
          fail     <= 1'b0;
          cur_addr <= '0;
          last_q   <= last_addr;
          state    <= ST_READY;
        end
        ST_READY: if (flash_ready) begin
          src_req <= 1'b1;
          state   <= ST_FETCH;
        end
        ST_FETCH: if (src_valid) begin
          expect_q  <= src_data;
          src_req   <= 1'b0;
          pulse_cnt <= PCW'(1);
          state     <= ST_SETUP;
        end
        ST_SETUP: if (bus_ack) state <= ST_DATA;
        ST_DATA: if (bus_ack) begin
          tmr_load <= 1'b1;
          tmr_val  <= TW'(PROG_WAIT);
          state    <= ST_PWAIT;
        end
        ST_PWAIT: if (tmr_fire) state <= ST_VCMD;
        ST_VCMD: if (bus_ack) begin
          tmr_load <= 1'b1;
          tmr_val  <= TW'(VERIFY_WAIT);
          state    <= ST_VWAIT;
        end
        ST_VWAIT: if (tmr_fire) state <= ST_READ;
        ST_READ: if (bus_ack) state <= ST_CHECK;
        ST_CHECK: begin
          if (bus_rdata == expect_q) begin
            if (cur_addr == last_q) begin
              ok_q  <= 1'b1;
              state <= ST_EXIT;
            end else begin
              cur_addr <= cur_addr + 1'b1;
              src_req  <= 1'b1;
              state    <= ST_FETCH;
            end
          end else if (pulse_cnt == PCW'(MAX_PULSES)) begin
            ok_q      <= 1'b0;
            fail_addr <= cur_addr;
            state     <= ST_EXIT;
          end else begin
            pulse_cnt <= pulse_cnt + 1'b1;
            state     <= ST_SETUP;
          end
        end
        ST_EXIT: if (bus_ack) begin
          done  <= 1'b1;
          busy  <= 1'b0;
          pass  <= ok_q;
          fail  <= ~ok_q;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int MAX_PULSES  = 25,
  parameter int PROG_WAIT   = 500,
  parameter int VERIFY_WAIT = 300,
  parameter int WE_CYCLES   = 3,
  parameter int OE_CYCLES   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              flash_ready,
  input  logic [ADDR_W-1:0] last_addr,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              src_req,
  output logic [ADDR_W-1:0] src_addr,
  input  logic              src_valid,
  input  logic [BYTE_W-1:0] src_data,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [BYTE_W-1:0] fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [BYTE_W-1:0] fl_dq_in
);
  localparam int WAIT_MAX = (PROG_WAIT > VERIFY_WAIT) ? PROG_WAIT : VERIFY_WAIT;
  localparam int TW       = $clog2(WAIT_MAX + 1);
  localparam int PCW      = $clog2(MAX_PULSES + 1);

  logic              bus_req, bus_rd, bus_ack;
  logic [ADDR_W-1:0] bus_addr;
  logic [BYTE_W-1:0] bus_data, bus_rdata;
  logic              tmr_load, tmr_fire;
  logic [TW-1:0]     tmr_val;
  logic [PCW-1:0]    pulse_cnt;

  fps_ctrl #(
    .ADDR_W(ADDR_W), .MAX_PULSES(MAX_PULSES), .PROG_WAIT(PROG_WAIT),
    .VERIFY_WAIT(VERIFY_WAIT), .TW(TW), .PCW(PCW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .flash_ready(flash_ready),
    .last_addr(last_addr), .busy(busy), .done(done), .pass(pass),
    .fail(fail), .fail_addr(fail_addr), .src_req(src_req),
    .cur_addr(src_addr), .src_valid(src_valid), .src_data(src_data),
    .bus_req(bus_req), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_fire(tmr_fire),
    .pulse_cnt(pulse_cnt)
  );

  fps_bus #(
    .ADDR_W(ADDR_W), .WE_CYCLES(WE_CYCLES), .OE_CYCLES(OE_CYCLES)
  ) u_bus (
    .clk(clk), .rst(rst), .req(bus_req), .rd(bus_rd), .addr_i(bus_addr),
    .data_i(bus_data), .ack(bus_ack), .rdata(bus_rdata), .ce_n(fl_ce_n),
    .we_n(fl_we_n), .oe_n(fl_oe_n), .addr_o(fl_addr), .dq_o(fl_dq_out),
    .dq_oe(fl_dq_oe), .dq_i(fl_dq_in)
  );

  fps_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .fire(tmr_fire)
  );
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int ADDR_W     = 17,
  parameter int PCW        = 5,
  parameter int MAX_PULSES = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic              fl_ce_n,
  input logic              fl_we_n,
  input logic              fl_oe_n,
  input logic              fl_dq_oe,
  input logic [PCW-1:0]    pulse_cnt
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe));

  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (rst)
    pulse_cnt <= PCW'(MAX_PULSES));

  p_fail_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> $stable(fail_addr));

  p_verdict_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));

  p_no_drive_read_r12: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe);
endmodule

bind flash_prog_seq fps_checker #(
  .ADDR_W(ADDR_W), .PCW(PCW), .MAX_PULSES(MAX_PULSES)
) u_fps_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .pass(pass), .fail(fail), .fail_addr(fail_addr), .fl_ce_n(fl_ce_n),
  .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_dq_oe(fl_dq_oe),
  .pulse_cnt(pulse_cnt)
);

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
  localparam int AW   = 4;
  localparam int MAXP = 25;
  localparam int PW   = 6;
  localparam int VW   = 4;
  localparam int NV   = 6;
  // {last_addr, slow_addr, pulses_needed, seed}
  localparam logic [31:0] VEC [0:NV-1] = '{
    32'h03_09_01_05, 32'h07_02_03_11, 32'h05_05_19_23,
    32'h06_04_1A_31, 32'h00_00_01_47, 32'h0F_00_1E_5C
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, flash_ready = 1'b0;
  logic [AW-1:0] last_addr = '0;
  logic busy, done, pass, fail, src_req, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0] fail_addr, src_addr, fl_addr;
  logic src_valid = 1'b0;
  logic [7:0] src_data = 8'h00, fl_dq_out, fl_dq_in;

  flash_prog_seq #(
    .ADDR_W(AW), .MAX_PULSES(MAXP), .PROG_WAIT(PW), .VERIFY_WAIT(VW),
    .WE_CYCLES(3), .OE_CYCLES(4)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .flash_ready(flash_ready),
    .last_addr(last_addr), .busy(busy), .done(done), .pass(pass),
    .fail(fail), .fail_addr(fail_addr), .src_req(src_req),
    .src_addr(src_addr), .src_valid(src_valid), .src_data(src_data),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic model_clr = 1'b0;
  int slow_a = 0, slow_n = 1;
  logic [7:0] seed = 8'h00;

  function automatic logic [7:0] pat(input int a, input logic [7:0] s);
    return 8'((a * 37 + int'(s)) & 8'h7F);
  endfunction

  // flash model and bus monitor
  logic [7:0] mem [0:15];
  int hits [0:15];
  int mode = 0, n_prog = 0, n_order = 0, n_seq = 0, n_pw = 0, n_vw = 0;
  int n_excl = 0, n_drv = 0, n_early = 0, n_fetch = 0, n_fetch_err = 0;
  int n_done = 0, last_prog = -1, t_fall = 0, t_data = 0, t_vcmd = 0;
  bit arm_pw = 0, arm_vw = 0, prev_we = 1, prev_oe = 1;
  logic [7:0] last_wdata = 8'hAA;

  assign fl_dq_in = mem[fl_addr];

  always @(posedge clk) begin
    cyc++;
    if (model_clr) begin
      for (int i = 0; i < 16; i++) begin mem[i] = 8'hFF; hits[i] = 0; end
      mode = 0; n_prog = 0; n_order = 0; n_seq = 0; n_pw = 0; n_vw = 0;
      n_excl = 0; n_drv = 0; n_early = 0; n_fetch = 0; n_fetch_err = 0;
      n_done = 0; last_prog = -1; arm_pw = 0; arm_vw = 0;
      last_wdata = 8'hAA;
    end else if (!rst) begin
      if (prev_we && !fl_we_n) t_fall = cyc;
      if (!prev_we && fl_we_n && !fl_ce_n) begin
        last_wdata = fl_dq_out;
        if (mode == 1) begin
          n_prog++;
          if (!(int'(fl_addr) == last_prog ||
                int'(fl_addr) == last_prog + 1)) n_seq++;
          last_prog = int'(fl_addr);
          hits[fl_addr]++;
          if (hits[fl_addr] >= ((int'(fl_addr) == slow_a) ? slow_n : 1))
            mem[fl_addr] = fl_dq_out;
          t_data = cyc; arm_pw = 1; mode = 0;
        end else if (fl_dq_out == 8'h40) begin
          mode = 1;
        end else if (fl_dq_out == 8'hC0) begin
          if (!arm_pw) n_order++;
          else if (t_fall - t_data < PW) n_pw++;
          arm_pw = 0; arm_vw = 1; t_vcmd = cyc; mode = 2;
        end else begin
          mode = 0;
        end
      end
      if (prev_oe && !fl_oe_n) begin
        if (!arm_vw || cyc - t_vcmd < VW) n_vw++;
        arm_vw = 0;
      end
      if (!fl_we_n && !fl_oe_n) n_excl++;
      if (!fl_oe_n && fl_dq_oe) n_drv++;
      if (!flash_ready && (!fl_ce_n || src_req)) n_early++;
      if (src_req && src_valid) begin
        if (int'(src_addr) != n_fetch) n_fetch_err++;
        n_fetch++;
      end
      if (done) n_done++;
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  // byte source: answers one cycle after a request
  always @(negedge clk) begin
    src_valid <= src_req && !src_valid;
    src_data  <= pat(int'(src_addr), seed);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    finish_run();
  end

  task automatic run_vec(input int i, input int hold);
    int last, exp_pulses, exp_fetch;
    bit exp_pass, seen;
    last   = int'(VEC[i][31:24]);
    slow_a = int'(VEC[i][23:16]);
    slow_n = int'(VEC[i][15:8]);
    seed   = VEC[i][7:0];
    exp_pass   = (slow_a > last) || (slow_n <= MAXP);
    exp_pulses = exp_pass ? (last + 1 + ((slow_a <= last) ? slow_n - 1 : 0))
                          : (slow_a + MAXP);
    exp_fetch  = exp_pass ? last + 1 : slow_a + 1;
    @(negedge clk);
    model_clr = 1'b1; last_addr = AW'(last); flash_ready = (hold == 0);
    @(negedge clk);
    model_clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(n_early == 0 && busy, "R10 quiet while supply not ready", n_early, 0);
      flash_ready = 1'b1;
    end
    repeat (30) @(negedge clk);
    start = 1'b1;                       // R10: ignored while busy
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int k = 0; k < 40000 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R9 run ends with done", int'(seen), 1);
    repeat (60) @(negedge clk);
    chk(n_done == 1, "R9/R10 exactly one done pulse", n_done, 1);
    chk(pass == exp_pass, "R8 pass verdict", int'(pass), int'(exp_pass));
    chk(fail == !exp_pass, "R7 fail verdict", int'(fail), int'(!exp_pass));
    if (!exp_pass)
      chk(int'(fail_addr) == slow_a, "R7 failing address", int'(fail_addr), slow_a);
    chk(n_prog == exp_pulses, "R6 program pulse count", n_prog, exp_pulses);
    chk(n_fetch == exp_fetch && n_fetch_err == 0, "R5 in-order fetch",
        n_fetch, exp_fetch);
    chk(last_wdata == 8'h00,
        exp_pass ? "R8 read mode restored" : "R9 read mode restored",
        int'(last_wdata), 0);
    chk(n_order == 0 && n_seq == 0, "R2 command order", n_order + n_seq, 0);
    chk(n_pw == 0, "R3 program delay", n_pw, 0);
    chk(n_vw == 0, "R4 verify delay", n_vw, 0);
    chk(n_excl == 0, "R11 strobes exclusive", n_excl, 0);
    chk(n_drv == 0, "R12 no drive during read", n_drv, 0);
    if (exp_pass)
      for (int a = 0; a <= last; a++)
        chk(mem[a] == pat(a, seed), "R5 programmed content",
            int'(mem[a]), int'(pat(a, seed)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !fail, "R1 reset status", int'(busy), 0);
    chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R1 reset bus idle",
        int'(fl_ce_n), 1);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) run_vec(i, (i == 0) ? 40 : 0);
    chk(fl_ce_n && !busy, "R1 bus quiet after runs", int'(fl_ce_n), 1);
    finish_run();
  end
endmodule